// File: doc/BRIEF.md
# Time-Multiplexed Multichannel FIR Filter

This block is a direct-form, non-symmetric, single-rate FIR filter that serves several interleaved channels with a single bank of multipliers. Samples from `NCH` channels enter on one bus in a fixed round-robin order, one per valid cycle. Each channel's sample rate is therefore the clock rate divided by `NCH`. Inside the block, every unit delay of an ordinary tap line becomes a run of `NCH` registers. As a result, each of the `NTAPS` multipliers always combines samples that belong to the same channel.

The coefficients are fixed at compile time. The products go into a fully pipelined adder tree at full precision, with no rounding and no saturation. Each result leaves the block tagged with the index of the channel it belongs to. It appears a fixed number of cycles after the input sample that produced it.

Top module: `tmfir`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0 and `out_chan` is 0. Every delay register holds zero, so the first outputs of each channel are computed as if all earlier samples of that channel were zero.
- R2: The first valid sample after reset belongs to channel 0. Each valid sample advances the channel index by one, wrapping from `NCH-1` back to 0. Cycles with `in_valid` low do not advance the channel index.
- R3: For the n-th valid sample x_c[n] of channel c, the result is the sum over k = 0..NTAPS-1 of h[k]·x_c[n-k]. The coefficients are h[k] = 23k+7 for even k and h[k] = -(19k+11) for odd k. All values are two's complement.
- R4: `out_valid` equals `in_valid` delayed by exactly LAT = 1 + ceil(log2(NTAPS)) cycles. With the defaults, LAT is 4.
- R5: `out_chan` on a valid output equals the channel index of the input sample that produced it.
- R6: When `in_valid` is low, the value on `in_data` is ignored and the stored history does not shift. Later results of every channel are the same as if the idle cycle had never occurred.
- R7: `out_data` is DW+CW+ceil(log2(NTAPS)) bits wide and signed. It is exact for any input and coefficient values, including runs of the most negative and most positive input.
- R8: Channels are independent: a nonzero sample in one channel never changes any result of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | The sample on `in_data` is valid this cycle |
| in_data | input | DW | Signed input sample of the current channel |
| out_valid | output | 1 | The result on `out_data` is valid |
| out_chan | output | CHW | Channel index of the result (CHW = max(1, ceil(log2(NCH)))) |
| out_data | output | AW | Signed full-precision filter result |

## Verification
- A single impulse is placed in one channel while the others carry zeros. A tap line that mixed channels would spread the impulse into the wrong channels, or space its echoes other than `NCH` samples apart.
- Random gaps in `in_valid` are filled with junk data. A design that shifted history or advanced the channel index on idle cycles would misalign every later result and its channel tag.
- Long runs of the most negative and most positive sample test the width of the sums. A narrow accumulator would wrap there.
- Valid and channel are compared on every clock. An off-by-one in the pipeline depth would show up on the very first output.

// File: rtl/tmfir_pkg.sv
package tmfir_pkg;

  // Compile-time coefficient of tap k
  function automatic int coef_val(input int k);
    if ((k % 2) == 0) return 23 * k + 7;
    else              return -(19 * k + 11);
  endfunction

  // Number of adder-tree levels for n leaves
  function automatic int tree_lvls(input int n);
    if (n > 1) return $clog2(n);
    else       return 0;
  endfunction

endpackage

// File: rtl/tmfir_tapline.sv
module tmfir_tapline #(
  parameter int DW   = 16,
  parameter int NTAPS = 8,
  parameter int NCH  = 4,
  parameter int CHW  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic signed [DW-1:0] taps [NTAPS],
  output logic [CHW-1:0]       chan
);
  localparam int DLEN = (NTAPS - 1) * NCH;
  localparam int SRL  = (DLEN > 0) ? DLEN : 1;

  logic signed [DW-1:0] sr_q   [SRL];
  logic signed [DW-1:0] sr_nxt [SRL];
  logic [CHW-1:0]       chan_q, chan_nxt;

  always_comb begin
    sr_nxt[0] = in_data;
    for (int i = 1; i < SRL; i++) sr_nxt[i] = sr_q[i-1];
    chan_nxt = chan_q;
    if (in_valid) chan_nxt = (chan_q == CHW'(NCH - 1)) ? '0 : chan_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SRL; i++) sr_q[i] <= '0;
      chan_q <= '0;
    end else if (in_valid) begin
      for (int i = 0; i < SRL; i++) sr_q[i] <= sr_nxt[i];
      chan_q <= chan_nxt;
    end
  end

  // tap k reads the sample k*NCH valid cycles back
  assign taps[0] = in_data;
  for (genvar k = 1; k < NTAPS; k++) begin : g_tap
    assign taps[k] = sr_q[k*NCH-1];
  end

  assign chan = chan_q;

  // R2
  chan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && chan_q == CHW'(NCH - 1)) |=> (chan_q == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sr_q[SRL-1]) && $stable(chan_q)));

endmodule

// File: rtl/tmfir_mults.sv
module tmfir_mults
  import tmfir_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int NTAPS = 8,
  parameter int CHW   = 2,
  parameter int PW    = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [CHW-1:0]       in_chan,
  input  logic signed [DW-1:0] taps [NTAPS],
  output logic signed [PW-1:0] prod [NTAPS],
  output logic                 v_q,
  output logic [CHW-1:0]       chan_q
);
  logic signed [PW-1:0] prod_nxt [NTAPS];
  logic signed [PW-1:0] prod_q   [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    localparam logic signed [CW-1:0] C = CW'(coef_val(k));
    always_comb prod_nxt[k] = PW'(taps[k]) * PW'(C);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prod_q[k] <= '0;
      else if (in_valid) prod_q[k] <= prod_nxt[k];
    end
    assign prod[k] = prod_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      chan_q <= '0;
    end else begin
      v_q    <= in_valid;
      chan_q <= in_valid ? in_chan : chan_q;
    end
  end

endmodule

// File: rtl/tmfir_addtree.sv
module tmfir_addtree
  import tmfir_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int PW    = 32,
  parameter int AW    = 35,
  parameter int CHW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [PW-1:0] prod [NTAPS],
  input  logic                 in_v,
  input  logic [CHW-1:0]       in_chan,
  output logic signed [AW-1:0] sum,
  output logic                 out_v,
  output logic [CHW-1:0]       out_chan
);
  localparam int LV = tree_lvls(NTAPS);
  localparam int P  = 1 << LV;
  localparam int NN = (P > 1) ? P - 1 : 1;

  logic signed [AW-1:0] leaf [P];

  for (genvar k = 0; k < P; k++) begin : g_leaf
    if (k < NTAPS) begin : g_real
      assign leaf[k] = AW'(prod[k]);
    end else begin : g_pad
      assign leaf[k] = '0;
    end
  end

  if (LV == 0) begin : g_flat
    assign sum      = leaf[0];
    assign out_v    = in_v;
    assign out_chan = in_chan;
  end else begin : g_tree
    logic signed [AW-1:0] node_q   [1:NN];
    logic signed [AW-1:0] node_nxt [1:NN];
    logic [LV-1:0]        v_sr;
    logic [CHW-1:0]       c_sr [LV];

    for (genvar i = 1; i < P; i++) begin : g_node
      logic signed [AW-1:0] lhs, rhs;
      if (2 * i >= P) begin : g_lf
        assign lhs = leaf[2*i-P];
        assign rhs = leaf[2*i+1-P];
      end else begin : g_in
        assign lhs = node_q[2*i];
        assign rhs = node_q[2*i+1];
      end
      always_comb node_nxt[i] = lhs + rhs;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) node_q[i] <= '0;
        else        node_q[i] <= node_nxt[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_sr <= '0;
        for (int j = 0; j < LV; j++) c_sr[j] <= '0;
      end else begin
        v_sr[0] <= in_v;
        c_sr[0] <= in_chan;
        for (int j = 1; j < LV; j++) begin
          v_sr[j] <= v_sr[j-1];
          c_sr[j] <= c_sr[j-1];
        end
      end
    end

    assign sum      = node_q[1];
    assign out_v    = v_sr[LV-1];
    assign out_chan = c_sr[LV-1];
  end

endmodule

// File: rtl/tmfir.sv
module tmfir
  import tmfir_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int NTAPS = 8,
  parameter int NCH   = 4,
  parameter int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int AW    = DW + CW + tree_lvls(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic [CHW-1:0]       out_chan,
  output logic signed [AW-1:0] out_data
);
  localparam int PW  = DW + CW;
  localparam int LAT = 1 + tree_lvls(NTAPS);
  localparam int SCW = $clog2(LAT + 1) + 1;

  // asynchronous assert, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic signed [DW-1:0] taps [NTAPS];
  logic [CHW-1:0]       cur_chan;
  logic signed [PW-1:0] prod [NTAPS];
  logic                 m_v;
  logic [CHW-1:0]       m_chan;

  tmfir_tapline #(.DW(DW), .NTAPS(NTAPS), .NCH(NCH), .CHW(CHW)) u_tap (
    .clk(clk), .rst_n(rst_sync), .in_valid(in_valid), .in_data(in_data),
    .taps(taps), .chan(cur_chan));

  tmfir_mults #(.DW(DW), .CW(CW), .NTAPS(NTAPS), .CHW(CHW), .PW(PW)) u_mul (
    .clk(clk), .rst_n(rst_sync), .in_valid(in_valid), .in_chan(cur_chan),
    .taps(taps), .prod(prod), .v_q(m_v), .chan_q(m_chan));

  tmfir_addtree #(.NTAPS(NTAPS), .PW(PW), .AW(AW), .CHW(CHW)) u_sum (
    .clk(clk), .rst_n(rst_sync), .prod(prod), .in_v(m_v), .in_chan(m_chan),
    .sum(out_data), .out_v(out_valid), .out_chan(out_chan));

  // cycles since reset release, saturating, for the latency check
  logic [SCW-1:0] since_q, since_nxt;
  always_comb since_nxt = (since_q == SCW'(LAT)) ? since_q : since_q + 1'b1;
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) since_q <= '0;
    else           since_q <= since_nxt;
  end

  // R4
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (since_q == SCW'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

  // R5
  chan_seq_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (out_valid && $past(out_valid) && since_q == SCW'(LAT)) |->
      (out_chan == (($past(out_chan) == CHW'(NCH - 1)) ? '0 : $past(out_chan) + 1'b1)));

endmodule

// File: tb/tmfir_test.sv
`timescale 1ns/1ps
module tmfir_test;
  localparam int DW = 16, CW = 16, NTAPS = 8, NCH = 4;
  localparam int CHW = 2;
  localparam int AW  = DW + CW + $clog2(NTAPS);
  localparam int LAT = 1 + $clog2(NTAPS);
  localparam int DEPTH = 4096;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [DW-1:0] in_data;
  logic out_valid;
  logic [CHW-1:0] out_chan;
  logic signed [AW-1:0] out_data;

  always #2.5 clk = ~clk;

  tmfir uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
             .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data));

  int checks = 0, errors = 0, k = 0, vcnt = 0;
  bit done = 0;
  bit     ev [DEPTH];
  longint ed [DEPTH];
  int     ec [DEPTH];
  longint hist [NCH][NTAPS];

  function automatic longint h(input int t);
    return (t % 2 == 0) ? longint'(23 * t + 7) : -longint'(19 * t + 11);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, k, act, exp_v);
    end
  endtask

  // R3 R4 R5 R7 R8: compare outputs with the behavioural model every cycle
  task automatic step(input bit v, input int d);
    bit xv; longint xd; int xc;
    xv = (k >= LAT) ? ev[k-LAT] : 1'b0;
    xd = (k >= LAT) ? ed[k-LAT] : 0;
    xc = (k >= LAT) ? ec[k-LAT] : 0;
    chk(out_valid == xv, "R4 valid", longint'(out_valid), longint'(xv));
    if (xv) begin
      chk(int'(out_chan) == xc, "R5 chan", longint'(out_chan), longint'(xc));
      chk(longint'(out_data) == xd, "R3/R7/R8 data", longint'(out_data), xd);
    end
    ev[k] = v; ed[k] = 0; ec[k] = 0;
    if (v) begin
      int c;
      longint s;
      c = vcnt % NCH;
      for (int t = NTAPS - 1; t > 0; t--) hist[c][t] = hist[c][t-1];
      hist[c][0] = longint'(d);
      s = 0;
      for (int t = 0; t < NTAPS; t++) s += h(t) * hist[c][t];
      ed[k] = s; ec[k] = c; vcnt++;
    end
    in_valid = v;
    in_data  = DW'(d);
    k++;
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int t = 0; t < NTAPS; t++) hist[c][t] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
    chk(out_data == '0, "R1 data", longint'(out_data), 0);
    chk(out_chan == '0, "R1 chan", longint'(out_chan), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2 R8: impulse in channel 2 only
    for (int i = 0; i < 48; i++) step(1'b1, (i == 6) ? 1000 : 0);
    // R3: full-rate random samples
    for (int i = 0; i < 400; i++) step(1'b1, int'($urandom_range(0, 65535)) - 32768);
    // R6: idle gaps carrying junk data
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 1) == 1) step(1'b1, int'($urandom_range(0, 65535)) - 32768);
      else                           step(1'b0, int'($urandom_range(0, 65535)) - 32768);
    end
    // R7: extreme values
    for (int i = 0; i < 64; i++) step(1'b1, -32768);
    for (int i = 0; i < 64; i++) step(1'b1, 32767);
    for (int i = 0; i < 64; i++) step(1'b1, (i % 2 == 0) ? -32768 : 32767);
    for (int i = 0; i < LAT + 3; i++) step(1'b0, 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d", k);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule